// File: doc/BRIEF.md
# Single-Cycle Harvard Load/Store Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. Instruction fetch and data access use two separate memory ports. The instruction port is read-only and returns its word in the same cycle as the address. The data port also returns read data in the same cycle, and it writes on the rising edge while its write enable is high. Control is pure combinational decode of a fixed 32-bit instruction word. This decode drives a set of named selects: immediate extension, second operand, destination register, write-back source and next-PC source.

The core covers these instructions:
- register-register and register-immediate arithmetic, logic and compare;
- word loads and stores addressed as base register plus signed displacement;
- branches that test a register against zero;
- absolute jumps, and jumps through a register, each with an optional link into register 31.

The program counter, the register file and the data memory all update on the same rising edge. A synchronous active-high reset returns the program counter to zero and clears the register file.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC (`imem_addr`) becomes 0 and all registers become 0.
- R2: Opcode 0x00 with bits 10:6 zero is register-register: rd (bits 15:11) gets rs (25:21) op rt (20:16), with function code (bits 5:0) 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x26 XOR, 0x2A signed less-than, 0x2B unsigned less-than (result 1 or 0).
- R3: Register-immediate writes rt with rs op imm (bits 15:0). The immediate is sign-extended for 0x08 add, 0x0A signed less-than and 0x0B unsigned less-than. It is zero-extended for 0x0C AND, 0x0D OR and 0x0E XOR.
- R4: Register 0 always reads as 0, and writes to it are discarded.
- R5: Opcode 0x23 loads the data word at rs + sign-extended displacement into rt. Opcode 0x2B writes rt to that address, with `dmem_we` high for that instruction's cycle only.
- R6: Opcode 0x04 branches when rs is zero, and opcode 0x05 branches when rs is nonzero. A taken branch goes to PC+4 + (sign-extended offset << 2). Otherwise the next PC is PC+4.
- R7: Opcode 0x02 jumps to {PC+4 bits 31:28, bits 25:0, 2'b00}. Opcode 0x03 does the same and also writes PC+4 into register 31.
- R8: Opcode 0x12 sets the PC to rs. Opcode 0x13 sets the PC to rs and writes PC+4 into register 31.
- R9: Any other opcode, and any register-register word with an unlisted function code or nonzero bits 10:6, writes no register and no memory, and advances the PC by 4.
- R10: `dmem_we` is high only for a store instruction, and never while `rst` is high.
- R11: Every instruction other than a branch or jump advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data (value of rt) |
| dmem_we | output | 1 | Data write enable, sampled on the rising edge |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, combinational |

## Verification
The hardest case to reach from the ports is a change that never appears on them directly. Two examples are an undefined instruction that wrongly writes a register, and a write aimed at register 0. Both affect only internal state. To expose them, the program runs such instructions against registers that it later stores to memory. The data port then carries the value that would have been corrupted. Link values from both link-writing jumps are stored the same way. A counted loop inside a subroutine drives the same branch through both taken and not-taken outcomes before a register-indirect return.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);
    localparam int IMM_W  = 16;
    localparam int JIDX_W = 26;
    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(NREG - 1);

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] OP_BEQZ  = 6'h04;
    localparam logic [5:0] OP_BNEZ  = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_SLTIU = 6'h0B;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_XORI  = 6'h0E;
    localparam logic [5:0] OP_JR    = 6'h12;
    localparam logic [5:0] OP_JALR  = 6'h13;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_SLTU
    } alu_op_e;

    typedef enum logic       { EXT_SIGN, EXT_ZERO }            ext_sel_e;
    typedef enum logic [1:0] { B_REG, B_IMM, B_ZERO }          bsrc_e;
    typedef enum logic [1:0] { DST_RT, DST_RD, DST_LINK }      regdst_e;
    typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK }       wbsrc_e;
    typedef enum logic [1:0] { PC_SEQ, PC_BR, PC_REG, PC_ABS } pcsrc_e;

    typedef struct packed {
        ext_sel_e ext_sel;
        bsrc_e    bsrc;
        regdst_e  regdst;
        wbsrc_e   wbsrc;
        pcsrc_e   pcsrc;
        logic     br_if_zero;
        alu_op_e  alu_op;
        logic     reg_write;
        logic     mem_write;
    } ctrl_t;
endpackage

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);
    logic [W-1:0] sum;
    logic [W-1:0] diff;

    assign sum  = a + b;
    assign diff = a - b;

    always_comb begin
        case (op)
            ALU_ADD:  y = sum;
            ALU_SUB:  y = diff;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLTU: y = {{(W-1){1'b0}}, (a < b)};
            default:  y = sum;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NUM  = NREG,
    localparam int AW  = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs_d [NUM];
    logic [W-1:0] regs_q [NUM];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       shamt_zero,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl.ext_sel    = EXT_SIGN;
        ctrl.bsrc       = B_REG;
        ctrl.regdst     = DST_RT;
        ctrl.wbsrc      = WB_ALU;
        ctrl.pcsrc      = PC_SEQ;
        ctrl.br_if_zero = 1'b0;
        ctrl.alu_op     = ALU_ADD;
        ctrl.reg_write  = 1'b0;
        ctrl.mem_write  = 1'b0;

        case (opcode)
            OP_REG: begin
                ctrl.regdst    = DST_RD;
                ctrl.reg_write = shamt_zero;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_XOR:  ctrl.alu_op = ALU_XOR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    FN_SLTU: ctrl.alu_op = ALU_SLTU;
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OP_ADDI, OP_SLTI, OP_SLTIU: begin
                ctrl.bsrc      = B_IMM;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = (opcode == OP_ADDI) ? ALU_ADD :
                                 (opcode == OP_SLTI) ? ALU_SLT : ALU_SLTU;
            end
            OP_ANDI, OP_ORI, OP_XORI: begin
                ctrl.ext_sel   = EXT_ZERO;
                ctrl.bsrc      = B_IMM;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = (opcode == OP_ANDI) ? ALU_AND :
                                 (opcode == OP_ORI)  ? ALU_OR  : ALU_XOR;
            end
            OP_LW: begin
                ctrl.bsrc      = B_IMM;
                ctrl.wbsrc     = WB_MEM;
                ctrl.reg_write = 1'b1;
            end
            OP_SW: begin
                ctrl.bsrc      = B_IMM;
                ctrl.mem_write = 1'b1;
            end
            OP_BEQZ, OP_BNEZ: begin
                ctrl.bsrc       = B_ZERO;
                ctrl.alu_op     = ALU_OR;
                ctrl.pcsrc      = PC_BR;
                ctrl.br_if_zero = (opcode == OP_BEQZ);
            end
            OP_J: begin
                ctrl.pcsrc = PC_ABS;
            end
            OP_JAL: begin
                ctrl.pcsrc     = PC_ABS;
                ctrl.regdst    = DST_LINK;
                ctrl.wbsrc     = WB_LINK;
                ctrl.reg_write = 1'b1;
            end
            OP_JR: begin
                ctrl.pcsrc = PC_REG;
            end
            OP_JALR: begin
                ctrl.pcsrc     = PC_REG;
                ctrl.regdst    = DST_LINK;
                ctrl.wbsrc     = WB_LINK;
                ctrl.reg_write = 1'b1;
            end
            default: begin
                ctrl.reg_write = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sc_pcunit.sv
module sc_pcunit
    import sc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  pcsrc_e            pcsrc,
    input  logic              br_if_zero,
    input  logic              alu_zero,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   imm_ext,
    input  logic [JIDX_W-1:0] jidx,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   pc_plus4
);
    localparam int HI_W = XLEN - JIDX_W - 2;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } pc_state_t;

    pc_state_t st_d;
    pc_state_t st_q;
    logic      take;

    assign pc_plus4 = st_q.pc + XLEN'(4);
    assign take     = br_if_zero ? alu_zero : ~alu_zero;

    always_comb begin
        st_d = st_q;
        case (pcsrc)
            PC_SEQ:  st_d.pc = pc_plus4;
            PC_BR:   st_d.pc = take ? (pc_plus4 + {imm_ext[XLEN-3:0], 2'b00}) : pc_plus4;
            PC_REG:  st_d.pc = rs_val;
            PC_ABS:  st_d.pc = {pc_plus4[XLEN-1 -: HI_W], jidx, 2'b00};
            default: st_d.pc = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc <= RESET_PC;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc = st_q.pc;
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);
    logic [5:0]        opcode;
    logic [5:0]        funct;
    logic [RIDX_W-1:0] rs_idx;
    logic [RIDX_W-1:0] rt_idx;
    logic [RIDX_W-1:0] rd_idx;
    logic [IMM_W-1:0]  imm16;
    logic              shamt_zero;

    ctrl_t             ctrl;
    logic [XLEN-1:0]   rs_val;
    logic [XLEN-1:0]   rt_val;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   alu_b;
    logic [XLEN-1:0]   alu_y;
    logic              alu_zero;
    logic [XLEN-1:0]   pc_plus4;
    logic [RIDX_W-1:0] dst_idx;
    logic [XLEN-1:0]   wb_val;
    logic              rf_we;

    assign opcode     = imem_data[31:26];
    assign rs_idx     = imem_data[25:21];
    assign rt_idx     = imem_data[20:16];
    assign rd_idx     = imem_data[15:11];
    assign shamt_zero = (imem_data[10:6] == '0);
    assign funct      = imem_data[5:0];
    assign imm16      = imem_data[15:0];

    sc_decode u_dec (
        .opcode     (opcode),
        .funct      (funct),
        .shamt_zero (shamt_zero),
        .ctrl       (ctrl)
    );

    // ExtSel
    assign imm_ext = (ctrl.ext_sel == EXT_ZERO) ? {{(XLEN-IMM_W){1'b0}}, imm16}
                                                : {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};

    // BSrc
    always_comb begin
        case (ctrl.bsrc)
            B_REG:   alu_b = rt_val;
            B_IMM:   alu_b = imm_ext;
            default: alu_b = '0;
        endcase
    end

    sc_alu #(.W(XLEN)) u_alu (
        .op   (ctrl.alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // RegDst
    always_comb begin
        case (ctrl.regdst)
            DST_RT:  dst_idx = rt_idx;
            DST_RD:  dst_idx = rd_idx;
            default: dst_idx = LINK_REG;
        endcase
    end

    // WBSrc
    always_comb begin
        case (ctrl.wbsrc)
            WB_ALU:  wb_val = alu_y;
            WB_MEM:  wb_val = dmem_rdata;
            default: wb_val = pc_plus4;
        endcase
    end

    assign rf_we = ctrl.reg_write;

    sc_regfile #(.W(XLEN), .NUM(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (rs_idx),
        .ra2 (rt_idx),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (rf_we),
        .wa  (dst_idx),
        .wd  (wb_val)
    );

    sc_pcunit #(.RESET_PC(RESET_PC)) u_pc (
        .clk        (clk),
        .rst        (rst),
        .pcsrc      (ctrl.pcsrc),
        .br_if_zero (ctrl.br_if_zero),
        .alu_zero   (alu_zero),
        .rs_val     (rs_val),
        .imm_ext    (imm_ext),
        .jidx       (imem_data[JIDX_W-1:0]),
        .pc         (imem_addr),
        .pc_plus4   (pc_plus4)
    );

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_write & ~rst;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [5:0]  opcode,
    input logic [15:0] imm16,
    input logic [4:0]  rs_field,
    input logic [31:0] rs_val,
    input logic        rf_we,
    input logic        dmem_we,
    input logic [31:0] dmem_addr
);
    logic [31:0] sext;
    logic [31:0] br_tgt;
    logic        is_flow;
    logic        is_known;
    logic        rst_seen_q;

    assign sext    = {{16{imm16[15]}}, imm16};
    assign br_tgt  = imem_addr + 32'd4 + {sext[29:0], 2'b00};
    assign is_flow = (opcode == OP_J) || (opcode == OP_JAL) || (opcode == OP_BEQZ) ||
                     (opcode == OP_BNEZ) || (opcode == OP_JR) || (opcode == OP_JALR);
    assign is_known = is_flow || (opcode == OP_REG) || (opcode == OP_ADDI) ||
                      (opcode == OP_SLTI) || (opcode == OP_SLTIU) || (opcode == OP_ANDI) ||
                      (opcode == OP_ORI) || (opcode == OP_XORI) || (opcode == OP_LW) ||
                      (opcode == OP_SW);

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1: one edge after reset was sampled, the PC is zero
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            assert_pc_reset_R1: assert (imem_addr == 32'h0);
        end
    end

    // R10: no data write while reset is held
    always @(negedge clk) begin
        if (rst === 1'b1) begin
            assert_no_we_in_reset_R10: assert (!dmem_we);
        end
    end

    assert_we_only_store_R10: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (opcode == OP_SW));

    assert_store_addr_R5: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (dmem_addr == rs_val + sext));

    assert_r0_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rs_field == 5'd0) |-> (rs_val == 32'h0));

    assert_undef_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !is_known |-> (!rf_we && !dmem_we));

    assert_seq_pc_R11: assert property (@(posedge clk) disable iff (rst)
        !is_flow |=> (imem_addr == $past(imem_addr) + 32'd4));

    assert_beqz_taken_R6: assert property (@(posedge clk) disable iff (rst)
        ((opcode == OP_BEQZ) && (rs_val == 32'h0)) |=> (imem_addr == $past(br_tgt)));

    assert_bnez_fall_R6: assert property (@(posedge clk) disable iff (rst)
        ((opcode == OP_BNEZ) && (rs_val == 32'h0)) |=> (imem_addr == $past(imem_addr) + 32'd4));

    assert_jr_target_R8: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_JR) |=> (imem_addr == $past(rs_val)));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .opcode    (imem_data[31:26]),
    .imm16     (imem_data[15:0]),
    .rs_field  (imem_data[25:21]),
    .rs_val    (rs_val),
    .rf_we     (rf_we),
    .dmem_we   (dmem_we),
    .dmem_addr (dmem_addr)
);

// File: tb/sim_sc_core.sv
module sim_sc_core;
    localparam int PERIOD = 10;
    localparam int MWORDS = 64;
    localparam int NCYC   = 100;

    logic        clk;
    logic        rst;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;

    logic [31:0] imem [MWORDS];
    logic [31:0] dmem [MWORDS];
    logic [31:0] ref_mem [MWORDS];
    logic [31:0] ref_reg [32];

    int n_checks = 0;
    int n_fails  = 0;
    logic go = 1'b0;
    logic mon_done = 1'b0;

    typedef struct packed {
        logic [31:0] pc;
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [31:0] pc_req;
        logic [31:0] st_req;
    } exp_t;

    exp_t sb [$];

    sc_core u0 (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    initial clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input int idx);
        return {op, 26'(idx)};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input logic [31:0] req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Reference model from the requirements; driver pushes one item per cycle.
    task automatic drive_expected;
        logic [31:0] pc = 32'h0;
        logic [31:0] prev_tag = "R1";
        for (int c = 0; c < NCYC; c++) begin
            logic [31:0] ins = imem[pc[7:2]];
            logic [5:0]  op = ins[31:26];
            logic [5:0]  fn = ins[5:0];
            logic [31:0] a = ref_reg[ins[25:21]];
            logic [31:0] b = ref_reg[ins[20:16]];
            logic [31:0] se = {{16{ins[15]}}, ins[15:0]};
            logic [31:0] ze = {16'h0, ins[15:0]};
            logic [31:0] pc4 = pc + 32'd4;
            logic [31:0] npc = pc4;
            logic [31:0] val = '0;
            logic [4:0]  dst = ins[20:16];
            logic        wr = 1'b0;
            logic [31:0] tag = "R11";
            exp_t it;
            it = '0;
            it.pc = pc;
            it.pc_req = prev_tag;
            it.st_req = "R10";
            case (op)
                6'h00: begin
                    dst = ins[15:11];
                    wr = (ins[10:6] == 5'd0);
                    case (fn)
                        6'h20: val = a + b;
                        6'h22: val = a - b;
                        6'h24: val = a & b;
                        6'h25: val = a | b;
                        6'h26: val = a ^ b;
                        6'h2A: val = {31'd0, $signed(a) < $signed(b)};
                        6'h2B: val = {31'd0, a < b};
                        default: begin wr = 1'b0; tag = "R9"; end
                    endcase
                end
                6'h08: begin wr = 1; val = a + se; end
                6'h0A: begin wr = 1; val = {31'd0, $signed(a) < $signed(se)}; end
                6'h0B: begin wr = 1; val = {31'd0, a < se}; end
                6'h0C: begin wr = 1; val = a & ze; end
                6'h0D: begin wr = 1; val = a | ze; end
                6'h0E: begin wr = 1; val = a ^ ze; end
                6'h23: begin wr = 1; val = ref_mem[(a + se) >> 2]; end
                6'h2B: begin
                    it.we = 1'b1; it.addr = a + se; it.data = b; it.st_req = "R5";
                    ref_mem[(a + se) >> 2] = b;
                end
                6'h04: begin tag = "R6"; if (a == 0) npc = pc4 + {se[29:0], 2'b00}; end
                6'h05: begin tag = "R6"; if (a != 0) npc = pc4 + {se[29:0], 2'b00}; end
                6'h02: begin tag = "R7"; npc = {pc4[31:28], ins[25:0], 2'b00}; end
                6'h03: begin tag = "R7"; npc = {pc4[31:28], ins[25:0], 2'b00}; wr = 1; dst = 5'd31; val = pc4; end
                6'h12: begin tag = "R8"; npc = a; end
                6'h13: begin tag = "R8"; npc = a; wr = 1; dst = 5'd31; val = pc4; end
                default: tag = "R9";
            endcase
            if (wr && dst != 5'd0) ref_reg[dst] = val;
            sb.push_back(it);
            prev_tag = tag;
            pc = npc;
        end
    endtask

    // Monitor: pops one expected item per cycle and compares with the ports.
    initial begin
        wait (go);
        while (sb.size() > 0) begin
            exp_t it;
            #1;
            it = sb.pop_front();
            check(imem_addr, it.pc, it.pc_req, "pc");
            check({31'd0, dmem_we}, {31'd0, it.we}, it.st_req, "dmem_we");
            if (it.we && dmem_we) begin
                check(dmem_addr, it.addr, "R5", "store address");
                check(dmem_wdata, it.data, "R5", "store data");
            end
            @(negedge clk);
        end
        mon_done = 1'b1;
    end

    initial begin
        #(PERIOD * 5000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        for (int i = 0; i < MWORDS; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
        for (int i = 0; i < 32; i++) ref_reg[i] = 32'h0;
        dmem[0] = 32'h0000_0007;
        dmem[1] = 32'hFFFF_FFF0;
        dmem[2] = 32'h1234_5678;

        imem[0]  = enc_i(6'h23, 0, 1, 16'd0);
        imem[1]  = enc_i(6'h23, 0, 2, 16'd4);
        imem[2]  = enc_i(6'h23, 0, 3, 16'd8);
        imem[3]  = enc_r(6'h20, 1, 2, 4);
        imem[4]  = enc_r(6'h22, 1, 2, 5);
        imem[5]  = enc_r(6'h24, 3, 2, 6);
        imem[6]  = enc_r(6'h25, 3, 2, 7);
        imem[7]  = enc_r(6'h26, 3, 1, 8);
        imem[8]  = enc_r(6'h2A, 2, 1, 9);
        imem[9]  = enc_r(6'h2B, 2, 1, 10);
        imem[10] = enc_i(6'h08, 1, 11, 16'hFFFB);
        imem[11] = enc_i(6'h0C, 3, 12, 16'hFFF0);
        imem[12] = enc_i(6'h0D, 0, 13, 16'h8001);
        imem[13] = enc_i(6'h0E, 2, 14, 16'hFFFF);
        imem[14] = enc_i(6'h0A, 2, 15, 16'hFFFF);
        imem[15] = enc_i(6'h0B, 1, 16, 16'hFFFF);
        imem[16] = enc_i(6'h08, 1, 0, 16'd5);
        imem[17] = enc_r(6'h20, 0, 1, 17);
        imem[18] = enc_i(6'h3F, 1, 18, 16'h0040);
        imem[19] = enc_r(6'h07, 1, 2, 18);
        imem[20] = enc_i(6'h05, 0, 0, 16'd5);
        imem[21] = enc_i(6'h04, 0, 0, 16'd1);
        imem[22] = enc_i(6'h08, 0, 18, 16'd99);
        imem[23] = enc_j(6'h03, 48);
        for (int k = 1; k <= 18; k++) imem[23 + k] = enc_i(6'h2B, 0, k, 16'(32'h44 + 4 * (k - 1)));
        imem[42] = enc_i(6'h08, 0, 21, 16'd224);
        imem[43] = enc_i(6'h13, 21, 0, 16'd0);
        imem[44] = enc_i(6'h2B, 0, 31, 16'h0098);
        imem[45] = enc_j(6'h02, 45);
        imem[48] = enc_i(6'h08, 0, 19, 16'd3);
        imem[49] = enc_i(6'h08, 19, 19, 16'hFFFF);
        imem[50] = enc_i(6'h2B, 0, 19, 16'h0040);
        imem[51] = enc_i(6'h05, 19, 0, 16'hFFFD);
        imem[52] = enc_i(6'h2B, 0, 31, 16'h008C);
        imem[53] = enc_i(6'h12, 31, 0, 16'd0);
        imem[56] = enc_i(6'h2B, 0, 31, 16'h0090);
        imem[57] = enc_i(6'h12, 31, 0, 16'd0);

        for (int i = 0; i < MWORDS; i++) ref_mem[i] = dmem[i];
        drive_expected();

        repeat (3) @(negedge clk);
        check(imem_addr, 32'h0, "R1", "pc in reset");
        check({31'd0, dmem_we}, 32'd0, "R10", "dmem_we in reset");
        rst = 1'b0;
        go = 1'b1;
        wait (mon_done);

        check(dmem[20], 32'hFFFF_FFF7, "R2", "add result r4");
        check(dmem[23], 32'hFFFF_FFF8, "R2", "or result r7");
        check(dmem[25], 32'h0000_0001, "R2", "signed less-than r9");
        check(dmem[27], 32'h0000_0002, "R3", "addi negative imm r11");
        check(dmem[28], 32'h0000_5670, "R3", "andi zero-extended r12");
        check(dmem[29], 32'h0000_8001, "R3", "ori zero-extended r13");
        check(dmem[30], 32'hFFFF_000F, "R3", "xori zero-extended r14");
        check(dmem[31], 32'h0000_0001, "R3", "slti sign-extended r15");
        check(dmem[33], 32'h0000_0007, "R4", "write to r0 discarded");
        check(dmem[34], 32'h0000_0000, "R9", "undefined ops left r18");
        check(dmem[16], 32'h0000_0000, "R6", "loop counter final store");
        check(dmem[35], 32'h0000_0060, "R7", "jal link value");
        check(dmem[36], 32'h0000_00B0, "R8", "jalr link value");
        check(dmem[38], 32'h0000_00B0, "R8", "link after return");
        for (int i = 0; i < MWORDS; i++) check(dmem[i], ref_mem[i], "R5", "data memory image");

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(imem_addr, 32'h0, "R1", "pc after mid-run reset");
        check({31'd0, dmem_we}, 32'd0, "R10", "dmem_we under reset");
        summary();
        $finish;
    end
endmodule